// File: doc/BRIEF.md
# Instruction Context Propagation Engine

This block schedules which stored instruction contexts apply to upcoming instructions. It holds seven slots. Each slot has a 40-bit schedule queue, a fill offset and a 24-bit context word. A set command names a slot (1 to 7) and supplies a new context word and a 21-bit immediate. The lowest set bit of the immediate acts as an end marker. The bits above that marker form the payload, and the payload is appended to the named slot's queue at its fill offset, after any entries already queued there.

Bit 0 of every queue applies to the instruction being issued now. The block ORs together the contexts of all slots whose bit 0 is set and shows the result combinationally. When the selected contexts do not share one type, the block raises an illegal flag instead of a merged value. An advance pulse marks that the current instruction has been issued. On that pulse every queue shifts down by one place.

Top module: `ctxp_engine`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties every queue, zeroes every fill offset and clears every context word, so that after reset `ctx_valid`, `ctx_illegal` and `ctx_out` are all 0.
- R2: A set command (`set_valid` high) whose `set_index` is between 1 and 7 replaces slot `set_index`'s context word with `set_context` at once. Bits already queued in that slot then select the new word. A set command with `set_index` 0 changes no slot.
- R3: Let z be the number of trailing zero bits of `set_imm`, with z = 21 when `set_imm` is 0. The insert count is 20 − z, or 0 when z ≥ 20. The inserted bits are `set_imm[z+1]` up to `set_imm[20]`, and `set_imm[z+1]` lands at the lowest position, so it applies first.
- R4: The inserted bits are written starting at the slot's fill offset, and the offset then grows by the insert count. A second command therefore queues its bits after those of the first.
- R5: On an `advance` pulse every queue shifts right by one place, filling the top with zero. Every fill offset then decrements by one, holding at 0.
- R6: When `advance` and a set command occur in the same cycle, the shift is applied first and the insertion lands at the decremented offset.
- R7: Inserted bits that would fall beyond queue bit 39 are dropped, and the fill offset is held at 40.
- R8: `ctx_valid` is high when bit 0 of any queue is set. When all selected contexts share one type, `ctx_out` is the bitwise OR of their context words.
- R9: The context type is bits [23:19] of a context word. If the selected contexts do not all carry the same type, `ctx_illegal` is 1 and `ctx_out` is 0, while `ctx_valid` stays 1.
- R10: When no queue has bit 0 set, `ctx_valid` and `ctx_illegal` are 0 and `ctx_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Set command strobe |
| set_index | input | 3 | Slot number for the set command, 0 = none |
| set_context | input | 24 | New context word for the slot |
| set_imm | input | 21 | Marker-terminated schedule pattern |
| advance | input | 1 | Instruction issued; shift all queues |
| ctx_valid | output | 1 | At least one slot selected for the current instruction |
| ctx_illegal | output | 1 | Selected contexts carry differing types |
| ctx_out | output | 24 | Merged context for the current instruction |

## Verification
The hardest case to reach is a queue running into its 40-bit limit while bits are still queued. This must happen both with and without a shift in the same cycle. The stimulus gets there by issuing back-to-back full-payload commands into one slot, then repeating the sequence with `advance` held during the last insert. Near-exhaustive sweeps then vary two things independently: the position of the trailing marker, over all 22 values, and the mix of context types across all seven slots. A bit-by-bit model in the bench predicts every cycle of the drain.

// File: rtl/ctxp_pkg.sv
package ctxp_pkg;

  localparam int SLOTS     = 7;
  localparam int SCHED_LEN = 40;
  localparam int CTX_W     = 24;
  localparam int IMM_W     = 21;
  localparam int TYPE_W    = 5;
  localparam int PAY_W     = IMM_W - 1;
  localparam int IDX_W     = $clog2(SLOTS + 1);
  localparam int OFF_W     = $clog2(SCHED_LEN + 1);
  localparam int CNT_W     = $clog2(IMM_W + 1);

  // Number of zero bits below the lowest set bit; IMM_W for an all-zero word.
  function automatic logic [CNT_W-1:0] trail_zeros(input logic [IMM_W-1:0] imm);
    logic [CNT_W-1:0] tz;
    tz = CNT_W'(IMM_W);
    for (int i = IMM_W - 1; i >= 0; i--) begin
      if (imm[i]) tz = CNT_W'(i);
    end
    return tz;
  endfunction

  // How many schedule bits sit above the end marker.
  function automatic logic [CNT_W-1:0] insert_count(input logic [IMM_W-1:0] imm);
    logic [CNT_W-1:0] tz;
    tz = trail_zeros(imm);
    if (int'(tz) >= PAY_W) return '0;
    return CNT_W'(PAY_W - int'(tz));
  endfunction

  // Payload right-aligned: the bit just above the marker ends up at bit 0.
  function automatic logic [PAY_W-1:0] payload(input logic [IMM_W-1:0] imm);
    logic [IMM_W-1:0] sh;
    int tz;
    tz = int'(trail_zeros(imm));
    sh = imm >> (tz + 1);
    return sh[PAY_W-1:0];
  endfunction

  // Lay the payload into a queue starting at offset, dropping overflow bits.
  function automatic logic [SCHED_LEN-1:0] place(input logic [SCHED_LEN-1:0] base,
                                                 input logic [PAY_W-1:0] pay,
                                                 input logic [OFF_W-1:0] off);
    logic [SCHED_LEN+PAY_W-1:0] wide;
    wide = {{SCHED_LEN{1'b0}}, pay};
    wide = wide << off;
    return base | wide[SCHED_LEN-1:0];
  endfunction

  // Advance the fill offset, clamped to the queue length.
  function automatic logic [OFF_W-1:0] next_off(input logic [OFF_W-1:0] off,
                                                input logic [CNT_W-1:0] cnt);
    int s;
    s = int'(off) + int'(cnt);
    if (s > SCHED_LEN) return OFF_W'(SCHED_LEN);
    return OFF_W'(s);
  endfunction

endpackage

// File: rtl/ctxp_slot.sv
module ctxp_slot
  import ctxp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [CTX_W-1:0]     ctx_in,
  input  logic [IMM_W-1:0]     imm,
  input  logic                 adv,
  output logic                 lsb,
  output logic [CTX_W-1:0]     ctx_q
);

  logic [SCHED_LEN-1:0] sreg_q, sreg_shifted, sreg_d;
  logic [OFF_W-1:0]     off_q, off_shifted, off_d;
  logic [CNT_W-1:0]     ins_cnt;
  logic [PAY_W-1:0]     ins_bits;

  always_comb begin
    sreg_shifted = adv ? (sreg_q >> 1) : sreg_q;
    off_shifted  = (adv && off_q != '0) ? off_q - 1'b1 : off_q;
    ins_cnt      = insert_count(imm);
    ins_bits     = payload(imm);
    sreg_d       = wr ? place(sreg_shifted, ins_bits, off_shifted) : sreg_shifted;
    off_d        = wr ? next_off(off_shifted, ins_cnt) : off_shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      off_q  <= '0;
      ctx_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      off_q  <= off_d;
      if (wr) ctx_q <= ctx_in;
    end
  end

  assign lsb = sreg_q[0];

  // R1: reset leaves an empty slot
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (sreg_q == '0 && off_q == '0 && ctx_q == '0));

  // R7: offset never passes the queue length
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    off_q <= OFF_W'(SCHED_LEN));

  // R4: nothing is queued at or above the fill offset
  a_r4_clear_above_fill: assert property (@(posedge clk) disable iff (rst)
    (sreg_q >> off_q) == '0);

  // R5: a pure advance drains one place
  a_r5_drain_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr) |=> (sreg_q == ($past(sreg_q) >> 1)) &&
                     (off_q == (($past(off_q) == '0) ? '0 : $past(off_q) - 1'b1)));

  // R2: without a command or advance the slot holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !wr) |=> ($stable(sreg_q) && $stable(off_q) && $stable(ctx_q)));

endmodule

// File: rtl/ctxp_merge.sv
module ctxp_merge
  import ctxp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SLOTS-1:0]              sel,
  input  logic [SLOTS-1:0][CTX_W-1:0]   ctx,
  output logic                          valid,
  output logic                          illegal,
  output logic [CTX_W-1:0]              merged
);

  logic [CTX_W-1:0]  ctx_or;
  logic [TYPE_W-1:0] type_and, type_or;
  logic              any_sel, type_clash;

  // All selected types agree exactly when their AND equals their OR.
  always_comb begin
    ctx_or   = '0;
    type_and = '1;
    type_or  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (sel[i]) begin
        ctx_or   = ctx_or | ctx[i];
        type_and = type_and & ctx[i][CTX_W-1 -: TYPE_W];
        type_or  = type_or  | ctx[i][CTX_W-1 -: TYPE_W];
      end
    end
    any_sel    = |sel;
    type_clash = any_sel && (type_and != type_or);
  end

  assign valid   = any_sel;
  assign illegal = type_clash;
  assign merged  = (any_sel && !type_clash) ? ctx_or : '0;

  // R10: nothing selected gives a quiet output
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (merged == '0 && !illegal));

  // R9: a clash suppresses the merged word
  a_r9_clash_blocks: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (valid && merged == '0));

  // R8: a single selected slot passes its word through unchanged
  a_r8_single_pass: assert property (@(posedge clk) disable iff (rst)
    ($countones(sel) == 1) |-> (!illegal && (merged & ~ctx_or) == '0 && merged == ctx_or));

endmodule

// File: rtl/ctxp_engine.sv
module ctxp_engine
  import ctxp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               set_valid,
  input  logic [IDX_W-1:0]   set_index,
  input  logic [CTX_W-1:0]   set_context,
  input  logic [IMM_W-1:0]   set_imm,
  input  logic               advance,
  output logic               ctx_valid,
  output logic               ctx_illegal,
  output logic [CTX_W-1:0]   ctx_out
);

  logic [SLOTS-1:0]            slot_wr;
  logic [SLOTS-1:0]            slot_lsb;
  logic [SLOTS-1:0][CTX_W-1:0] slot_ctx;

  // Index 0 is reserved: it matches no slot.
  always_comb begin
    for (int i = 0; i < SLOTS; i++)
      slot_wr[i] = set_valid && (set_index == IDX_W'(i + 1));
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    ctxp_slot u_slot (
      .clk    (clk),
      .rst    (rst),
      .wr     (slot_wr[g]),
      .ctx_in (set_context),
      .imm    (set_imm),
      .adv    (advance),
      .lsb    (slot_lsb[g]),
      .ctx_q  (slot_ctx[g])
    );
  end

  ctxp_merge u_merge (
    .clk     (clk),
    .rst     (rst),
    .sel     (slot_lsb),
    .ctx     (slot_ctx),
    .valid   (ctx_valid),
    .illegal (ctx_illegal),
    .merged  (ctx_out)
  );

  // R2: at most one slot takes a command, and reserved index 0 takes none
  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    (set_valid && set_index == '0) |-> (slot_wr == '0));

endmodule

// File: tb/ctxp_engine_tb.sv
`timescale 1ns/100ps
module ctxp_engine_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        set_valid;
  logic [2:0]  set_index;
  logic [23:0] set_context;
  logic [20:0] set_imm;
  logic        advance;
  logic        ctx_valid, ctx_illegal;
  logic [23:0] ctx_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [39:0] m_sreg [7];
  int          m_off  [7];
  logic [23:0] m_ctx  [7];

  always #2.5 clk = ~clk;

  ctxp_engine u_dut (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_index(set_index),
    .set_context(set_context), .set_imm(set_imm), .advance(advance),
    .ctx_valid(ctx_valid), .ctx_illegal(ctx_illegal), .ctx_out(ctx_out)
  );

  function automatic logic [23:0] mk(input int ty, input int data);
    return {ty[4:0], data[18:0]};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 7; i++) begin
      m_sreg[i] = '0; m_off[i] = 0; m_ctx[i] = '0;
    end
  endtask

  task automatic check_val(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    bit any = 0; bit ill = 0; logic [4:0] t0 = '0; logic [23:0] orv = '0;
    for (int i = 0; i < 7; i++) begin
      if (m_sreg[i][0]) begin
        if (!any) t0 = m_ctx[i][23:19];
        else if (m_ctx[i][23:19] != t0) ill = 1;
        any = 1;
        orv = orv | m_ctx[i];
      end
    end
    check_val("ctx_valid", {31'b0, ctx_valid}, {31'b0, any});
    check_val("ctx_illegal", {31'b0, ctx_illegal}, {31'b0, ill});
    check_val("ctx_out", {8'b0, ctx_out}, (any && !ill) ? {8'b0, orv} : 32'b0);
  endtask

  task automatic model_step(input bit s, input int idx, input logic [23:0] c,
                            input logic [20:0] imm, input bit a);
    int tz, cnt;
    if (a) begin
      for (int i = 0; i < 7; i++) begin
        m_sreg[i] = m_sreg[i] >> 1;
        if (m_off[i] > 0) m_off[i]--;
      end
    end
    if (s && idx >= 1 && idx <= 7) begin
      m_ctx[idx-1] = c;
      tz = 0;
      while (tz < 21 && !imm[tz]) tz++;
      cnt = (tz >= 20) ? 0 : 20 - tz;
      for (int k = 0; k < cnt; k++) begin
        if (m_off[idx-1] + k < 40) m_sreg[idx-1][m_off[idx-1] + k] = imm[tz + 1 + k];
      end
      m_off[idx-1] = (m_off[idx-1] + cnt > 40) ? 40 : m_off[idx-1] + cnt;
    end
  endtask

  // Check what the current state shows, then apply one cycle of stimulus.
  task automatic step(input bit s, input int idx, input logic [23:0] c,
                      input logic [20:0] imm, input bit a);
    @(negedge clk);
    check_outputs();
    set_valid = s; set_index = idx[2:0]; set_context = c; set_imm = imm; advance = a;
    model_step(s, idx, c, imm, a);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, 1);
  endtask

  function automatic logic [20:0] with_marker(input logic [19:0] pay, input int tz);
    logic [41:0] w;
    if (tz >= 21) return '0;
    w = ({22'b0, pay} << (tz + 1)) | (42'd1 << tz);
    return w[20:0];
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; set_valid = 0; set_index = '0; set_context = '0; set_imm = '0; advance = 0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    cur_req = "R1";
    check_outputs();

    // Marker position sweep, all 22 cases, on slot 3
    cur_req = "R3";
    for (int tz = 0; tz <= 21; tz++) begin
      step(1, 3, mk(2, 16'h1000 + tz), with_marker(20'hAB35 ^ (tz * 20'h1111), tz), 0);
      drain(21);
    end

    // Appending behind existing entries
    cur_req = "R4";
    step(1, 2, mk(1, 19'h55), with_marker(20'h00005, 17), 0);
    step(1, 2, mk(1, 19'h55), with_marker(20'h0F0F3, 0), 0);
    drain(25);

    // Overflow truncation
    cur_req = "R7";
    step(1, 4, mk(3, 19'h7), 21'h1FFFFF, 0);
    step(1, 4, mk(3, 19'h7), with_marker(20'hA5A5A, 0), 0);
    step(1, 4, mk(3, 19'h7), 21'h1FFFFF, 0);
    drain(41);

    // Shift and insert in one cycle, including at the limit
    cur_req = "R6";
    step(1, 4, mk(3, 19'h9), 21'h1FFFFF, 0);
    step(1, 4, mk(3, 19'h9), with_marker(20'h33333, 0), 1);
    step(1, 4, mk(3, 19'h9), 21'h1FFFFF, 1);
    drain(41);

    cur_req = "R5";
    step(1, 6, mk(5, 19'h1), with_marker(20'h00013, 15), 0);
    drain(8);

    // Same-type merge across all seven slots
    cur_req = "R8";
    for (int k = 1; k <= 7; k++) begin
      logic [19:0] p = '0;
      for (int b = 0; b < 20; b++) if (((b + k) % (k + 1)) == 0 || b == k) p[b] = 1'b1;
      step(1, k, mk(2, 19'd1 << k), with_marker(p, 0), 0);
    end
    drain(21);

    // Type clashes, including types whose OR equals one of them
    cur_req = "R9";
    for (int k = 1; k <= 7; k++)
      step(1, k, mk(k % 4, 19'h100 << k), with_marker(20'hFFFFF >> (k * 2), 0), 0);
    drain(21);
    step(1, 1, mk(3, 19'h1), with_marker(20'h0000F, 0), 0);
    step(1, 5, mk(1, 19'h2), with_marker(20'h0000F, 0), 0);
    drain(6);

    // Replacement and the reserved index
    cur_req = "R2";
    step(1, 5, mk(4, 19'h11), with_marker(20'hFFFFF, 0), 0);
    step(0, 0, '0, '0, 1);
    step(1, 5, mk(4, 19'h22), 21'h100000, 0);
    step(1, 0, mk(7, 19'h7FFFF), 21'h1FFFFF, 0);
    for (int i = 0; i < 7; i++) step(1, 0, mk(i, 19'h3), with_marker(20'hFFFFF, i), 1);
    drain(41);

    cur_req = "R10";
    step(0, 0, '0, '0, 0);
    step(0, 0, '0, '0, 1);

    // Reset in the middle of a loaded state
    cur_req = "R1";
    step(1, 7, mk(6, 19'h4), 21'h1FFFFF, 0);
    step(1, 1, mk(6, 19'h8), 21'h1FFFFF, 0);
    @(negedge clk);
    check_outputs();
    set_valid = 0; advance = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    model_clear();
    check_outputs();
    step(0, 0, '0, '0, 1);
    @(negedge clk);
    check_outputs();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule